// File: doc/BRIEF.md
# Dual-Tap Programmable Pulse Delay

This block delays a single 1-bit signal by a programmable number of clock cycles and presents two independently delayed copies of it, called tap A and tap B. Both taps read one shared history of the input, so every rising and falling edge of the input reappears on each tap after the same number of cycles. The width of every pulse is therefore preserved. The delay of a tap is a fixed base offset plus its 4-bit code times a step size. Base and step are elaboration parameters, with defaults of 9 and 3 cycles, which give a range of 9 to 54 cycles.

Each tap has an enable input. While the enable is high, the code input passes straight through to the tap. On the first clock edge that samples the enable low, the code sampled on that same edge is captured, and it is held until the enable returns high. Any change to the effective code of a tap opens a settling window. During this window the tap's valid flag is low, and the window lasts as many cycles as the new delay. A system that does not need to latch codes ties the enable high.

Top module: `dual_tap_delay`

## Requirements
- R1: While `rst` is high, both data outputs and both valid flags are 0 on the next cycle. After release, each valid flag rises following the BASE-th clock edge that samples `rst` low.
- R2: While a tap's valid flag is high, its output after edge n equals the `din` value sampled at edge n−D. Here D = BASE + code × STEP, which is 9 to 54 cycles with the defaults. Input values sampled during reset count as 0.
- R3: A pulse of W cycles on `din` appears on each tap as a pulse of W cycles, with its rising edge D cycles after the input rising edge.
- R4: While a tap's enable is high and its code input changes, the effective code follows it, and the valid flag is low after the next edge.
- R5: When a change of effective code is sampled at edge c, the valid flag stays low through edge c+D−1 and is high after edge c+D, where D is the new delay.
- R6: The code sampled on the first edge whose enable is 0 is captured. Code changes on later edges with the enable still 0 do not change the delay, and the valid flag stays high.
- R7: Programming one tap has no effect on the other tap's valid flag or delay.
- R8: A new code that arrives during a settling window restarts the window with the delay of that newest code.
- R9: Raising the enable while the code input equals the held code opens no settling window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 1 | Signal to be delayed |
| en_a | input | 1 | Tap A code pass-through enable; 0 holds the captured code |
| code_a | input | 4 | Tap A delay code |
| en_b | input | 1 | Tap B code pass-through enable; 0 holds the captured code |
| code_b | input | 4 | Tap B delay code |
| dout_a | output | 1 | Tap A delayed copy of `din` |
| dout_b | output | 1 | Tap B delayed copy of `din` |
| valid_a | output | 1 | Tap A output trustworthy (settling window over) |
| valid_b | output | 1 | Tap B output trustworthy (settling window over) |

## Verification
The bench targets the extreme codes 0 and 15. An off-by-one tap index would show up there as an output shifted by one cycle from the reference. It drops the enable and changes the code on the same edge. A design that captured the code from the previous edge would then settle on the wrong delay, or open no window at all. The bench changes a code partway through a settling window, which a design that kept the first countdown would fail by asserting valid too early. It also re-enables a tap with an unchanged code and changes codes while a tap is latched, to catch a design that invalidates the tap when it should not, or lets held codes leak through.

// File: rtl/dly_pkg.sv
package dly_pkg;

    localparam int DEF_BASE   = 9;
    localparam int DEF_STEP   = 3;
    localparam int DEF_CODE_W = 4;
    localparam int NUM_TAPS   = 2;

    // Total delay in cycles that a given code selects.
    function automatic int tap_delay(input int base, input int step, input int code);
        return base + code * step;
    endfunction

endpackage

// File: rtl/dly_history.sv
module dly_history #(
    parameter int DEPTH = 54
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             din,
    output logic [DEPTH-1:0] hist
);

    typedef struct packed {
        logic [DEPTH-1:0] hist;
    } hist_t;

    hist_t st_d, st_q;

    // Bit 0 holds the newest sample; bit k is k cycles older.
    always_comb begin
        st_d.hist = {st_q.hist[DEPTH-2:0], din};
        if (rst) begin
            st_d.hist = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign hist = st_q.hist;

endmodule

// File: rtl/dly_tap_ctrl.sv
module dly_tap_ctrl
    import dly_pkg::*;
#(
    parameter int BASE   = DEF_BASE,
    parameter int STEP   = DEF_STEP,
    parameter int CODE_W = DEF_CODE_W,
    parameter int CNT_W  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [CODE_W-1:0] code_in,
    output logic [CODE_W-1:0] sel,
    output logic              valid
);

    typedef struct packed {
        logic [CODE_W-1:0] sel;
        logic              en_prev;
        logic [CNT_W-1:0]  cnt;
    } ctrl_t;

    ctrl_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.en_prev = en;
        // Follow the code while enabled and on the first edge seen low.
        if (en || st_q.en_prev) begin
            st_d.sel = code_in;
        end
        if (st_d.sel != st_q.sel) begin
            st_d.cnt = CNT_W'(tap_delay(BASE, STEP, int'(st_d.sel)));
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - CNT_W'(1);
        end
        if (rst) begin
            st_d.sel     = '0;
            st_d.en_prev = 1'b0;
            st_d.cnt     = CNT_W'(BASE);
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign sel   = st_q.sel;
    assign valid = (st_q.cnt == '0);

endmodule

// File: rtl/dly_tap_mux.sv
module dly_tap_mux
    import dly_pkg::*;
#(
    parameter int BASE   = DEF_BASE,
    parameter int STEP   = DEF_STEP,
    parameter int CODE_W = DEF_CODE_W,
    parameter int DEPTH  = 54
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DEPTH-1:0]  hist,
    input  logic [CODE_W-1:0] sel,
    output logic              dout
);

    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic out;
    } mux_t;

    mux_t             st_d, st_q;
    logic [IDX_W-1:0] idx;

    // The output register adds one cycle, so the tap sits one slot early.
    always_comb begin
        idx       = IDX_W'(tap_delay(BASE, STEP, int'(sel)) - 1);
        st_d.out  = hist[idx];
        if (rst) begin
            st_d.out = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign dout = st_q.out;

endmodule

// File: rtl/dual_tap_delay.sv
module dual_tap_delay
    import dly_pkg::*;
#(
    parameter int BASE   = DEF_BASE,
    parameter int STEP   = DEF_STEP,
    parameter int CODE_W = DEF_CODE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              din,
    input  logic              en_a,
    input  logic [CODE_W-1:0] code_a,
    input  logic              en_b,
    input  logic [CODE_W-1:0] code_b,
    output logic              dout_a,
    output logic              dout_b,
    output logic              valid_a,
    output logic              valid_b
);

    localparam int MAX_CODE = (1 << CODE_W) - 1;
    localparam int DEPTH    = BASE + MAX_CODE * STEP;
    localparam int CNT_W    = $clog2(DEPTH + 1);

    logic [DEPTH-1:0]    hist;
    logic [NUM_TAPS-1:0] en_v;
    logic [NUM_TAPS-1:0] valid_v;
    logic [NUM_TAPS-1:0] dout_v;
    logic [CODE_W-1:0]   code_v [NUM_TAPS];
    logic [CODE_W-1:0]   sel_v  [NUM_TAPS];

    assign en_v      = {en_b, en_a};
    assign code_v[0] = code_a;
    assign code_v[1] = code_b;

    dly_history #(
        .DEPTH (DEPTH)
    ) u_hist (
        .clk  (clk),
        .rst  (rst),
        .din  (din),
        .hist (hist)
    );

    for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
        dly_tap_ctrl #(
            .BASE   (BASE),
            .STEP   (STEP),
            .CODE_W (CODE_W),
            .CNT_W  (CNT_W)
        ) u_ctrl (
            .clk     (clk),
            .rst     (rst),
            .en      (en_v[g]),
            .code_in (code_v[g]),
            .sel     (sel_v[g]),
            .valid   (valid_v[g])
        );

        dly_tap_mux #(
            .BASE   (BASE),
            .STEP   (STEP),
            .CODE_W (CODE_W),
            .DEPTH  (DEPTH)
        ) u_mux (
            .clk  (clk),
            .rst  (rst),
            .hist (hist),
            .sel  (sel_v[g]),
            .dout (dout_v[g])
        );
    end

    assign dout_a  = dout_v[0];
    assign dout_b  = dout_v[1];
    assign valid_a = valid_v[0];
    assign valid_b = valid_v[1];

endmodule

// File: rtl/dual_tap_delay_chk.sv
module dual_tap_delay_chk #(
    parameter int BASE   = 9,
    parameter int CODE_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              en_a,
    input logic [CODE_W-1:0] code_a,
    input logic              en_b,
    input logic [CODE_W-1:0] code_b,
    input logic              dout_a,
    input logic              dout_b,
    input logic              valid_a,
    input logic              valid_b
);

    // Count samples with the valid flag low, so that the length of a
    // settling window can be checked without a deep $past.
    int low_a, low_b;

    always_ff @(posedge clk) begin
        if (rst || valid_a) low_a <= 0;
        else if (low_a < 1000) low_a <= low_a + 1;
        if (rst || valid_b) low_b <= 0;
        else if (low_b < 1000) low_b <= low_b + 1;
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (!dout_a && !dout_b && !valid_a && !valid_b));

    assert_change_drops_valid_a_R4: assert property (@(posedge clk) disable iff (rst)
        (en_a && $past(en_a) && code_a != $past(code_a)) |=> !valid_a);

    assert_change_drops_valid_b_R4: assert property (@(posedge clk) disable iff (rst)
        (en_b && $past(en_b) && code_b != $past(code_b)) |=> !valid_b);

    assert_settle_min_a_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(valid_a) |-> (low_a >= BASE));

    assert_settle_min_b_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(valid_b) |-> (low_b >= BASE));

    assert_held_code_ignored_a_R6: assert property (@(posedge clk) disable iff (rst)
        (!en_a && !$past(en_a) && valid_a) |=> valid_a);

    assert_held_code_ignored_b_R6: assert property (@(posedge clk) disable iff (rst)
        (!en_b && !$past(en_b) && valid_b) |=> valid_b);

endmodule

bind dual_tap_delay dual_tap_delay_chk #(
    .BASE   (BASE),
    .CODE_W (CODE_W)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .en_a    (en_a),
    .code_a  (code_a),
    .en_b    (en_b),
    .code_b  (code_b),
    .dout_a  (dout_a),
    .dout_b  (dout_b),
    .valid_a (valid_a),
    .valid_b (valid_b)
);

// File: tb/tb_dual_tap_delay.sv
module tb_dual_tap_delay;

    localparam int BASE = 9;
    localparam int STEP = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       din = 1'b0;
    logic       en_a = 1'b1;
    logic       en_b = 1'b1;
    logic [3:0] code_a = 4'd0;
    logic [3:0] code_b = 4'd0;
    logic       dout_a, dout_b, valid_a, valid_b;

    int         n_chk  = 0;
    int         n_fail = 0;
    int         cyc    = 0;
    bit         refm [0:4095];
    int         exp_da = BASE;
    int         exp_db = BASE;
    bit         mon_on = 1'b0;
    logic [15:0] lfsr  = 16'hACE1;

    always #5 clk = ~clk;

    dual_tap_delay dut (
        .clk     (clk),
        .rst     (rst),
        .din     (din),
        .en_a    (en_a),
        .code_a  (code_a),
        .en_b    (en_b),
        .code_b  (code_b),
        .dout_a  (dout_a),
        .dout_b  (dout_b),
        .valid_a (valid_a),
        .valid_b (valid_b)
    );

    function automatic int dly(input int code);
        return BASE + code * STEP;
    endfunction

    task automatic check_eq(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Reference history of din as seen at each edge (0 while in reset).
    always @(posedge clk) begin
        refm[cyc % 4096] <= rst ? 1'b0 : din;
        cyc <= cyc + 1;
    end

    // R2: continuous comparison against the reference while valid.
    always @(posedge clk) begin
        #2;
        if (mon_on && !rst) begin
            if (valid_a && (cyc - 1 - exp_da) >= 0)
                check_eq("R2 dout_a", int'(dout_a), int'(refm[(cyc - 1 - exp_da) % 4096]));
            if (valid_b && (cyc - 1 - exp_db) >= 0)
                check_eq("R2 dout_b", int'(dout_b), int'(refm[(cyc - 1 - exp_db) % 4096]));
        end
    end

    task automatic tick(input bit rnd);
        @(posedge clk);
        #3;
        if (rnd) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            din  = lfsr[0];
        end
    endtask

    task automatic wait_valid(output int na, output int nb);
        na = 0;
        nb = 0;
        for (int k = 1; k <= 200; k++) begin
            tick(1'b1);
            if (na == 0 && valid_a) na = k;
            if (nb == 0 && valid_b) nb = k;
            if (na != 0 && nb != 0) break;
        end
    endtask

    task automatic t_reset();
        int na, nb;
        rst = 1'b1;
        for (int k = 0; k < 4; k++) begin
            din = k[0];
            tick(1'b0);
            check_eq("R1 dout_a in reset", int'(dout_a), 0);
            check_eq("R1 dout_b in reset", int'(dout_b), 0);
            check_eq("R1 valid_a in reset", int'(valid_a), 0);
            check_eq("R1 valid_b in reset", int'(valid_b), 0);
        end
        rst = 1'b0;
        wait_valid(na, nb);
        check_eq("R1 valid_a rise after reset", na, BASE);
        check_eq("R1 valid_b rise after reset", nb, BASE);
        mon_on = 1'b1;
    endtask

    task automatic t_program(input int ca, input int cb);
        int na, nb, ea, eb;
        ea = (ca != int'(code_a)) ? dly(ca) + 1 : 1;
        eb = (cb != int'(code_b)) ? dly(cb) + 1 : 1;
        code_a = 4'(ca);
        code_b = 4'(cb);
        exp_da = dly(ca);
        exp_db = dly(cb);
        wait_valid(na, nb);
        check_eq("R5 settle length A", na, ea);
        check_eq("R5 settle length B", nb, eb);
        for (int k = 0; k < 70; k++) tick(1'b1);
    endtask

    task automatic t_pulse(input int width);
        int ra, fa, rb, fb;
        ra = 0; fa = 0; rb = 0; fb = 0;
        din = 1'b0;
        for (int k = 0; k < 60; k++) tick(1'b0);
        din = 1'b1;
        for (int k = 1; k <= 120; k++) begin
            tick(1'b0);
            if (k == width) din = 1'b0;
            if (ra == 0 && dout_a) ra = k;
            if (ra != 0 && fa == 0 && !dout_a) fa = k;
            if (rb == 0 && dout_b) rb = k;
            if (rb != 0 && fb == 0 && !dout_b) fb = k;
        end
        check_eq("R3 rise delay A", ra, exp_da + 1);
        check_eq("R3 pulse width A", fa - ra, width);
        check_eq("R3 rise delay B", rb, exp_db + 1);
        check_eq("R3 pulse width B", fb - rb, width);
    endtask

    task automatic t_latch();
        int na, nb, bad;
        en_a   = 1'b0;
        code_a = 4'd6;
        exp_da = dly(6);
        wait_valid(na, nb);
        check_eq("R6 same-edge capture settle A", na, dly(6) + 1);
        bad = 0;
        for (int k = 0; k < 40; k++) begin
            if (k % 5 == 0) code_a = 4'(k / 5 + 1);
            tick(1'b1);
            if (!valid_a) bad++;
        end
        check_eq("R6 held code ignored, valid_a low count", bad, 0);
        code_a = 4'd6;
        tick(1'b1);
        en_a = 1'b1;
        bad = 0;
        for (int k = 0; k < 20; k++) begin
            tick(1'b1);
            if (!valid_a) bad++;
        end
        check_eq("R9 re-enable same code, valid_a low count", bad, 0);
    endtask

    task automatic t_indep();
        int bad;
        code_a = 4'd13;
        exp_da = dly(13);
        bad = 0;
        for (int k = 0; k < dly(13) + 3; k++) begin
            tick(1'b1);
            if (!valid_b) bad++;
        end
        check_eq("R7 valid_b undisturbed by tap A", bad, 0);
        check_eq("R4 valid_a after settle", int'(valid_a), 1);
    endtask

    task automatic t_restart();
        int na, nb, bad;
        code_a = 4'd10;
        exp_da = dly(10);
        bad = 0;
        for (int k = 0; k < 5; k++) begin
            tick(1'b1);
            if (valid_a) bad++;
        end
        check_eq("R4 valid_a low after change", bad, 0);
        code_a = 4'd2;
        exp_da = dly(2);
        wait_valid(na, nb);
        check_eq("R8 restarted settle length A", na, dly(2) + 1);
        for (int k = 0; k < 40; k++) tick(1'b1);
    endtask

    initial begin
        #1500000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_program(5, 12);
        t_program(0, 15);
        t_program(15, 0);
        t_pulse(6);
        t_program(7, 3);
        t_pulse(1);
        t_latch();
        t_indep();
        t_restart();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule